// File: doc/BRIEF.md
# Turbo Tail-Bit Output Sequencer

This block is the output stage of a rate-1/3 turbo encoder, with optional rate-1/5 parity. Two recursive systematic constituent encoders run side by side. One takes the natural-order bit stream and the other takes the interleaved stream. Both streams arrive together under one valid strobe. A start pulse captures the block length `n` and the termination style, and the block then encodes `n` bit pairs. After the last pair it drives both encoders back to the all-zero state and sends out their termination bits. Each output cycle carries a ready flag, and a tail flag marks which encoder's termination bits are on the ports.

There are two termination styles. In the packed style the twelve tail bits of the two encoders go out over four cycles, three at a time, on three ports. In the side-by-side style each encoder terminates over three cycles while the other encoder's ports stay silent. In that style the second encoder's systematic tail bits are copied onto the first encoder's systematic port. A downstream ready input stalls the whole block. While it is low, nothing moves and every output holds its value.

Top module: `turbo_tail_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, every output is low.
- R2: The encoders are cleared at start. Each accepted pair (`in_valid` and `dn_ready` high in the data phase) appears on the ports one cycle later. In that cycle `out_valid` is 1, `sys1` carries the natural bit and `sys2` the interleaved bit. With register taps D1..D3, the feedback is a = u^D2^D3, `par0_*` = a^D1^D3 and `par1_*` = a^D1^D2^D3.
- R3: In the data phase, a cycle with `dn_ready` high and `in_valid` low produces an all-low output cycle and does not advance either encoder.
- R4: In packed style (`par_tail`=0) the twelve tail bits x1,z1,x2,z2,x3,z3 of the natural encoder and then the same six of the interleaved encoder go out three per cycle over four cycles. Within each cycle they appear in the order `sys1`, `par0_1`, `par0_2`. `sys2` and both `par1_*` are low during these four cycles.
- R5: In side-by-side style (`par_tail`=1) the first three tail cycles carry the natural encoder's x, z and y on `sys1`, `par0_1` and `par1_1`, with all of the second encoder's ports low. The next three cycles carry the interleaved encoder's x, z and y on `sys2`, `par0_2` and `par1_2`. In those cycles `sys1` equals `sys2`, and `par0_1` and `par1_1` are low.
- R6: `tail1` and `tail2` are never high together. In packed style each is high for two presented cycles, and in side-by-side style for three.
- R7: `out_valid` is high for n+4 presented cycles in packed style and n+6 in side-by-side style. Once the first tail cycle is out, it stays high until the last tail cycle.
- R8: A clock edge with `dn_ready` low changes no output and no internal state, and consumes no input.
- R9: `blk_done` is high only together with the final tail cycle of a block, once per block.
- R10: `start`, `blk_len` and `par_tail` are captured only while idle with `dn_ready` high. A start during a block and any `in_valid` outside the data phase are ignored. `blk_len` must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dn_ready | input | 1 | Downstream ready; low stalls the block |
| start | input | 1 | Begins a block when idle |
| blk_len | input | LEN_W | Block length n, captured at start |
| par_tail | input | 1 | Termination style: 0 packed, 1 side-by-side |
| in_valid | input | 1 | Qualifies the two input bits |
| nat_bit | input | 1 | Natural-order information bit |
| ilv_bit | input | 1 | Interleaved information bit |
| out_valid | output | 1 | Output ports carry a code cycle |
| sys1 | output | 1 | Systematic port, natural encoder |
| par0_1 | output | 1 | First parity, natural encoder |
| par1_1 | output | 1 | Second parity, natural encoder (rate 1/5) |
| sys2 | output | 1 | Systematic port, interleaved encoder |
| par0_2 | output | 1 | First parity, interleaved encoder |
| par1_2 | output | 1 | Second parity, interleaved encoder (rate 1/5) |
| tail1 | output | 1 | Natural encoder tail bits present |
| tail2 | output | 1 | Interleaved encoder tail bits present |
| blk_done | output | 1 | Final tail cycle of the block |

## Verification
The hardest situation to reach from the ports is a stall or an input gap that lands exactly on the boundary between the last data pair and the first tail cycle, or between the two encoders' tail groups. That is where the terminating register states and the tail index must both hold. The stimulus uses modular gap and stall patterns with different periods, together with block lengths down to one. Over many blocks these patterns slide past every phase boundary in both termination styles. A start pulse and a different length are injected mid-block to show they leave the block length unchanged.

// File: rtl/tts_pkg.sv
package tts_pkg;

    localparam int NUM_ENC    = 2;
    localparam int TAIL_STEPS = 3;
    localparam int SEQ_BITS   = NUM_ENC * TAIL_STEPS * 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_TAIL = 2'd2
    } phase_t;

    typedef struct packed {
        logic x;
        logic z;
        logic y;
    } code_t;

    typedef struct packed {
        logic vld;
        logic sys1;
        logic p0_1;
        logic p1_1;
        logic sys2;
        logic p0_2;
        logic p1_2;
        logic t1;
        logic t2;
        logic done;
    } out_t;

    // s[0] is the first delay tap, s[2] the last
    function automatic code_t rsc_code(input logic u, input logic [2:0] s);
        code_t c;
        logic  a;
        a   = u ^ s[1] ^ s[2];
        c.x = u;
        c.z = a ^ s[0] ^ s[2];
        c.y = a ^ s[0] ^ s[1] ^ s[2];
        return c;
    endfunction

    function automatic logic [2:0] rsc_next(input logic u, input logic [2:0] s);
        return {s[1], s[0], u ^ s[1] ^ s[2]};
    endfunction

    // Closed form of termination step k from frozen state s (feedback forced to zero)
    function automatic code_t tail_code(input logic [2:0] s, input logic [1:0] k);
        code_t c;
        case (k)
            2'd0:    begin c.x = s[1] ^ s[2]; c.z = s[0] ^ s[2]; c.y = s[0] ^ s[1] ^ s[2]; end
            2'd1:    begin c.x = s[0] ^ s[1]; c.z = s[1];        c.y = s[0] ^ s[1];        end
            default: begin c.x = s[0];        c.z = s[0];        c.y = s[0];               end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tts_ctrl.sv
module tts_ctrl
    import tts_pkg::*;
#(
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start,
    input  logic [LEN_W-1:0] blk_len,
    input  logic             par_in,
    input  logic             in_valid,
    output phase_t           phase,
    output logic [2:0]       tail_idx,
    output logic             par_mode,
    output logic             data_adv,
    output logic             clr,
    output logic             last_tail
);
    localparam logic [2:0] MUX_LAST = 3'(2 * NUM_ENC - 1);
    localparam logic [2:0] PAR_LAST = 3'(NUM_ENC * TAIL_STEPS - 1);

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;

    assign tail_idx  = cnt_q[2:0];
    assign data_adv  = en && (phase == PH_DATA) && in_valid;
    assign clr       = en && (phase == PH_IDLE) && start;
    assign last_tail = (phase == PH_TAIL) && (tail_idx == (par_mode ? PAR_LAST : MUX_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt_q    <= '0;
            len_q    <= '0;
            par_mode <= 1'b0;
        end else if (en) begin
            case (phase)
                PH_IDLE: if (start) begin
                    len_q    <= blk_len;
                    par_mode <= par_in;
                    cnt_q    <= '0;
                    phase    <= PH_DATA;
                end
                PH_DATA: if (in_valid) begin
                    if (cnt_q == len_q - LEN_W'(1)) begin
                        cnt_q <= '0;
                        phase <= PH_TAIL;
                    end else begin
                        cnt_q <= cnt_q + LEN_W'(1);
                    end
                end
                PH_TAIL: begin
                    if (last_tail) begin
                        cnt_q <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + LEN_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assert_tail_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TAIL) |-> (tail_idx <= PAR_LAST));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(phase) && $stable(cnt_q) && $stable(par_mode)));

endmodule

// File: rtl/tts_rsc.sv
module tts_rsc
    import tts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       adv,
    input  logic       u,
    output logic [2:0] st
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st <= '0;
        end else if (adv) begin
            st <= rsc_next(u, st);
        end
    end

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st == 3'b000));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(st));

endmodule

// File: rtl/tts_fmt.sv
module tts_fmt
    import tts_pkg::*;
#(
    parameter bit RATE_FIFTH = 1'b1
) (
    input  phase_t     phase,
    input  logic [2:0] tail_idx,
    input  logic       par_mode,
    input  logic       in_valid,
    input  logic       nat_bit,
    input  logic       ilv_bit,
    input  logic       last_tail,
    input  logic [2:0] st_nat,
    input  logic [2:0] st_ilv,
    output out_t       o
);
    out_t                raw;
    code_t               c_nat;
    code_t               c_ilv;
    code_t               tc;
    logic [SEQ_BITS-1:0] seq;
    logic [3:0]          base;
    logic [2:0]          k2;

    always_comb begin
        c_nat = rsc_code(nat_bit, st_nat);
        c_ilv = rsc_code(ilv_bit, st_ilv);
        for (int k = 0; k < TAIL_STEPS; k++) begin
            seq[2*k]                  = tail_code(st_nat, 2'(k)).x;
            seq[2*k+1]                = tail_code(st_nat, 2'(k)).z;
            seq[2*TAIL_STEPS+2*k]     = tail_code(st_ilv, 2'(k)).x;
            seq[2*TAIL_STEPS+2*k+1]   = tail_code(st_ilv, 2'(k)).z;
        end
        base = {1'b0, tail_idx[1:0], 1'b0} + {2'b00, tail_idx[1:0]};
        k2   = tail_idx - 3'(TAIL_STEPS);
        tc   = '0;
        raw  = '0;
        case (phase)
            PH_DATA: if (in_valid) begin
                raw.vld  = 1'b1;
                raw.sys1 = nat_bit;
                raw.p0_1 = c_nat.z;
                raw.p1_1 = c_nat.y;
                raw.sys2 = ilv_bit;
                raw.p0_2 = c_ilv.z;
                raw.p1_2 = c_ilv.y;
            end
            PH_TAIL: begin
                raw.vld  = 1'b1;
                raw.done = last_tail;
                if (par_mode) begin
                    if (tail_idx < 3'(TAIL_STEPS)) begin
                        tc       = tail_code(st_nat, tail_idx[1:0]);
                        raw.sys1 = tc.x;
                        raw.p0_1 = tc.z;
                        raw.p1_1 = tc.y;
                        raw.t1   = 1'b1;
                    end else begin
                        tc       = tail_code(st_ilv, k2[1:0]);
                        raw.sys1 = tc.x;
                        raw.sys2 = tc.x;
                        raw.p0_2 = tc.z;
                        raw.p1_2 = tc.y;
                        raw.t2   = 1'b1;
                    end
                end else begin
                    raw.sys1 = seq[base];
                    raw.p0_1 = seq[base + 4'd1];
                    raw.p0_2 = seq[base + 4'd2];
                    raw.t1   = (tail_idx[1:0] < 2'd2);
                    raw.t2   = (tail_idx[1:0] >= 2'd2);
                end
            end
            default: raw = '0;
        endcase
    end

    generate
        if (RATE_FIFTH) begin : g_rate5
            assign o = raw;
        end else begin : g_rate3
            always_comb begin
                o      = raw;
                o.p1_1 = 1'b0;
                o.p1_2 = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/turbo_tail_seq.sv
module turbo_tail_seq
    import tts_pkg::*;
#(
    parameter int LEN_W      = 13,
    parameter bit RATE_FIFTH = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dn_ready,
    input  logic             start,
    input  logic [LEN_W-1:0] blk_len,
    input  logic             par_tail,
    input  logic             in_valid,
    input  logic             nat_bit,
    input  logic             ilv_bit,
    output logic             out_valid,
    output logic             sys1,
    output logic             par0_1,
    output logic             par1_1,
    output logic             sys2,
    output logic             par0_2,
    output logic             par1_2,
    output logic             tail1,
    output logic             tail2,
    output logic             blk_done
);
    phase_t           phase;
    logic [2:0]       tail_idx;
    logic             par_mode;
    logic             data_adv;
    logic             clr;
    logic             last_tail;
    logic [NUM_ENC-1:0] u_bits;
    logic [2:0]       st [NUM_ENC];
    out_t             nxt;
    out_t             out_q;

    assign u_bits = {ilv_bit, nat_bit};

    tts_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (dn_ready),
        .start     (start),
        .blk_len   (blk_len),
        .par_in    (par_tail),
        .in_valid  (in_valid),
        .phase     (phase),
        .tail_idx  (tail_idx),
        .par_mode  (par_mode),
        .data_adv  (data_adv),
        .clr       (clr),
        .last_tail (last_tail)
    );

    generate
        for (genvar g = 0; g < NUM_ENC; g++) begin : g_enc
            tts_rsc u_rsc (
                .clk (clk),
                .rst (rst),
                .clr (clr),
                .adv (data_adv),
                .u   (u_bits[g]),
                .st  (st[g])
            );
        end
    endgenerate

    tts_fmt #(.RATE_FIFTH(RATE_FIFTH)) u_fmt (
        .phase     (phase),
        .tail_idx  (tail_idx),
        .par_mode  (par_mode),
        .in_valid  (in_valid),
        .nat_bit   (nat_bit),
        .ilv_bit   (ilv_bit),
        .last_tail (last_tail),
        .st_nat    (st[0]),
        .st_ilv    (st[1]),
        .o         (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (dn_ready) begin
            out_q <= nxt;
        end
    end

    assign out_valid = out_q.vld;
    assign sys1      = out_q.sys1;
    assign par0_1    = out_q.p0_1;
    assign par1_1    = out_q.p1_1;
    assign sys2      = out_q.sys2;
    assign par0_2    = out_q.p0_2;
    assign par1_2    = out_q.p1_2;
    assign tail1     = out_q.t1;
    assign tail2     = out_q.t2;
    assign blk_done  = out_q.done;

    assert_tail_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(tail1 && tail2));

    assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        !dn_ready |=> $stable(out_q));

    assert_tail_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (tail1 || tail2) |-> out_valid);

    assert_ready_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (tail1 || tail2) && !blk_done) |=> out_valid);

    assert_done_last_R9: assert property (@(posedge clk) disable iff (rst)
        blk_done |-> (tail2 && out_valid));

    assert_sys_route_R5: assert property (@(posedge clk) disable iff (rst)
        (par_mode && tail2) |-> (sys1 == sys2));

endmodule

// File: tb/turbo_tail_seq_bench.sv
`timescale 1ns/1ps
module turbo_tail_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dn_ready = 1'b1;
    logic        start = 1'b0;
    logic [12:0] blk_len = '0;
    logic        par_tail = 1'b0;
    logic        in_valid = 1'b0;
    logic        nat_bit = 1'b0;
    logic        ilv_bit = 1'b0;
    logic        out_valid, sys1, par0_1, par1_1, sys2, par0_2, par1_2, tail1, tail2, blk_done;

    always #2.5 clk = ~clk;

    turbo_tail_seq u_turbo_tail_seq (
        .clk (clk), .rst (rst), .dn_ready (dn_ready), .start (start),
        .blk_len (blk_len), .par_tail (par_tail), .in_valid (in_valid),
        .nat_bit (nat_bit), .ilv_bit (ilv_bit), .out_valid (out_valid),
        .sys1 (sys1), .par0_1 (par0_1), .par1_1 (par1_1), .sys2 (sys2),
        .par0_2 (par0_2), .par1_2 (par1_2), .tail1 (tail1), .tail2 (tail2),
        .blk_done (blk_done)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // behavioural reference
    int        m_ph = 0, m_n = 0, m_par = 0, m_cnt = 0, m_en = 0;
    int        ms [2][3];
    int        tx [2][3], tz [2][3], ty [2][3];
    int        seq [12];
    logic [9:0] exp_v = '0;
    string     exp_tag = "R1";

    function automatic logic [9:0] dut_vec();
        return {out_valid, sys1, par0_1, par1_1, sys2, par0_2, par1_2, tail1, tail2, blk_done};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_en = 0; exp_v = '0; exp_tag = "R1";
        end else if (!dn_ready) begin
            m_en = 0; exp_tag = "R8";
        end else begin
            m_en = 1;
            case (m_ph)
                0: begin
                    exp_v = '0; exp_tag = "R10";
                    if (start) begin
                        m_n = int'(blk_len); m_par = int'(par_tail); m_cnt = 0; m_ph = 1;
                        for (int e = 0; e < 2; e++) for (int j = 0; j < 3; j++) ms[e][j] = 0;
                    end
                end
                1: begin
                    if (in_valid) begin
                        int u [2]; int z [2]; int y [2];
                        u[0] = int'(nat_bit); u[1] = int'(ilv_bit);
                        for (int e = 0; e < 2; e++) begin
                            int a;
                            a = u[e] ^ ms[e][1] ^ ms[e][2];
                            z[e] = a ^ ms[e][0] ^ ms[e][2];
                            y[e] = a ^ ms[e][0] ^ ms[e][1] ^ ms[e][2];
                            ms[e][2] = ms[e][1]; ms[e][1] = ms[e][0]; ms[e][0] = a;
                        end
                        exp_v = {1'b1, 1'(u[0]), 1'(z[0]), 1'(y[0]), 1'(u[1]), 1'(z[1]), 1'(y[1]), 3'b000};
                        exp_tag = "R2";
                        m_cnt++;
                        if (m_cnt == m_n) begin
                            for (int e = 0; e < 2; e++) begin
                                int t [3];
                                for (int j = 0; j < 3; j++) t[j] = ms[e][j];
                                for (int k = 0; k < 3; k++) begin
                                    int uu, a;
                                    uu = t[1] ^ t[2];
                                    a  = uu ^ t[1] ^ t[2];
                                    tx[e][k] = uu;
                                    tz[e][k] = a ^ t[0] ^ t[2];
                                    ty[e][k] = a ^ t[0] ^ t[1] ^ t[2];
                                    t[2] = t[1]; t[1] = t[0]; t[0] = a;
                                end
                                for (int k = 0; k < 3; k++) begin
                                    seq[6*e+2*k]   = tx[e][k];
                                    seq[6*e+2*k+1] = tz[e][k];
                                end
                            end
                            m_ph = 2; m_cnt = 0;
                        end
                    end else begin
                        exp_v = '0; exp_tag = "R3";
                    end
                end
                default: begin
                    int last; bit dn;
                    last = m_par ? 5 : 3;
                    dn = (m_cnt == last);
                    if (m_par) begin
                        exp_tag = "R5";
                        if (m_cnt < 3)
                            exp_v = {1'b1, 1'(tx[0][m_cnt]), 1'(tz[0][m_cnt]), 1'(ty[0][m_cnt]),
                                     3'b000, 2'b10, dn};
                        else
                            exp_v = {1'b1, 1'(tx[1][m_cnt-3]), 2'b00, 1'(tx[1][m_cnt-3]),
                                     1'(tz[1][m_cnt-3]), 1'(ty[1][m_cnt-3]), 2'b01, dn};
                    end else begin
                        exp_tag = "R4";
                        exp_v = {1'b1, 1'(seq[3*m_cnt]), 1'(seq[3*m_cnt+1]), 1'b0, 1'b0,
                                 1'(seq[3*m_cnt+2]), 1'b0, (m_cnt < 2), (m_cnt >= 2), dn};
                    end
                    m_cnt++;
                    if (dn) begin m_ph = 0; m_cnt = 0; end
                end
            endcase
        end
    end

    int blk_rdy = 0, blk_t1 = 0, blk_t2 = 0, blk_dn = 0;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            vectors++;
            if (dut_vec() !== exp_v) begin
                miscompares++;
                $display("FAIL %s: outputs got %b expected %b at %0t", exp_tag, dut_vec(), exp_v, $time);
            end
            if (m_en != 0) begin
                if (out_valid) blk_rdy++;
                if (tail1)     blk_t1++;
                if (tail2)     blk_t2++;
                if (blk_done)  blk_dn++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int got, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    int seed = 32'h1bad5eed;

    task automatic run_block(input int n, input bit pm, input int gap_mod, input int stall_mod);
        blk_rdy = 0; blk_t1 = 0; blk_t2 = 0; blk_dn = 0;
        start = 1'b1; blk_len = 13'(n); par_tail = pm; dn_ready = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3 * n + 40; i++) begin
            in_valid = (gap_mod == 0) ? 1'b1 : ((i % gap_mod) != 1);
            dn_ready = (stall_mod == 0) ? 1'b1 : ((i % stall_mod) != 2);
            seed = seed * 1103515245 + 12345;
            nat_bit = seed[16];
            ilv_bit = seed[21];
            // R10: start with another length and style during the block must be ignored
            start = (i == 3);
            blk_len = (i == 3) ? 13'd99 : 13'(n);
            par_tail = (i == 3) ? ~pm : pm;
            @(negedge clk);
        end
        start = 1'b0; in_valid = 1'b0; dn_ready = 1'b1;
        @(negedge clk);
        check(blk_rdy == n + (pm ? 6 : 4), "R7 (ready count, R10 length kept)", blk_rdy, n + (pm ? 6 : 4));
        check(blk_t1 == (pm ? 3 : 2), "R6 tail1 count", blk_t1, pm ? 3 : 2);
        check(blk_t2 == (pm ? 3 : 2), "R6 tail2 count", blk_t2, pm ? 3 : 2);
        check(blk_dn == 1, "R9 done count", blk_dn, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(dut_vec() == 10'b0, "R1 reset state", int'(dut_vec()), 0);
        run_block(8, 1'b0, 0, 0);
        run_block(8, 1'b1, 0, 0);
        run_block(1, 1'b0, 0, 0);
        run_block(1, 1'b1, 0, 0);
        run_block(20, 1'b0, 3, 4);
        run_block(17, 1'b1, 3, 4);
        run_block(2, 1'b0, 2, 3);
        run_block(3, 1'b1, 5, 2);
        run_block(40, 1'b0, 0, 5);
        run_block(33, 1'b1, 7, 0);
        for (int b = 0; b < 12; b++) run_block(4 + b, 1'(b), (b % 4) + 2, (b % 3) + 3);
        finish_run();
    end

endmodule